// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that completes one instruction on every rising clock edge. It supports eight instructions: register add, add-immediate, word load, word store, branch-if-equal, jump, jump-and-link and jump-to-register. The core holds a program counter, a word-addressed instruction store, a word-addressed data store, a 32-entry register file and an adder/subtractor. It also has a sign extender, the branch and jump target arithmetic, and a decoder. The decoder first sorts each instruction into an enumerated kind and then produces a word of datapath control flags from that kind.

The instruction store has a write port. Test or boot logic fills it while the core is held in reset. After reset is released, the core fetches from address zero. Two combinational peek ports, one into the register file and one into the data store, let the surrounding logic observe the architectural state. The core has no multi-cycle sequencing, so it has no states and no transitions. Its only sequential elements are the program counter, the register file and the two stores, and all of them update on the same edge. The decoded instruction kinds are K_ADD, K_ADDI, K_LW, K_SW, K_BEQ, K_J, K_JAL, K_JR and K_NOP.

Top module: `cpu_core`

## Requirements
- R1: While rst_n is low the program counter is 0, and every register and every data word reads 0.
- R2: Opcode 0x00 with function 0x20 and shift field 0 writes rs+rt into rd. Every instruction that does not redirect control advances the program counter by 4. The program counter stays word aligned.
- R3: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt.
- R4: Opcode 0x2B stores rt at byte address rs+sext(imm), and opcode 0x23 loads that word into rt. The word index is address bits 7:2 for the default 64-word store. A store to an unaligned address is ignored, and a load from one returns 0.
- R5: Opcode 0x04 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. When they differ, the next PC is PC+4. Backward offsets are allowed.
- R6: Opcode 0x02 sets the PC to {PC+4 bits 31:28, bits 25:0 of the instruction, 2'b00}.
- R7: Opcode 0x03 jumps like R6 and, on the same edge, writes PC+4 into register 31.
- R8: Opcode 0x00 with function 0x08 sets the PC to the value of rs.
- R9: Register 0 always reads 0. Writes to it are discarded.
- R10: An instruction that reads and writes the same register uses the value from before the edge. A jump-to-register through register 31 that directly follows a jump-and-link's return path sees the linked value.
- R11: Any other opcode, or any other function code, acts as a no-op: PC+4 and no register or memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_wr_en | input | 1 | Write enable for the instruction store |
| imem_wr_addr | input | IAW (6) | Word index written in the instruction store |
| imem_wr_data | input | 32 | Instruction word to write |
| pc_out | output | 32 | Current program counter |
| reg_peek_addr | input | 5 | Register index to observe |
| reg_peek_data | output | 32 | Value of the observed register |
| mem_peek_addr | input | DAW (6) | Data-store word index to observe |
| mem_peek_data | output | 32 | Value of the observed data word |

## Verification
Two functions can land on one edge. A jump-and-link writes register 31 at the same moment the PC moves to the jump target, and an add whose destination is also its source reads and writes that register in the same cycle. The bench provokes the first with a call followed by a jump-to-register through register 31. It judges the result by the PC reached after the return and by the linked value. It provokes the second with add r1,r1,r1 and checks that the result is exactly double the value from before the edge, not a value fed back after the write.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    typedef logic [31:0] word_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;

    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_JR    = 6'h08;

    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        K_NOP, K_ADD, K_ADDI, K_LW, K_SW, K_BEQ, K_J, K_JAL, K_JR
    } kind_e;

    // Datapath steering word produced by the decoder.
    typedef struct packed {
        logic branch;   // conditional PC-relative redirect
        logic jump;     // absolute region jump
        logic imm_b;    // ALU operand B from sign-extended immediate
        logic sub;      // ALU subtracts instead of adds
        logic mem_we;   // data store write
        logic reg_we;   // register file write
        logic dst_rt;   // destination is rt instead of rd
        logic wd_mem;   // write-back value from data store
        logic link;     // write PC+4 into the link register
        logic jreg;     // next PC from rs
    } ctl_t;
endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    input  logic [4:0] shamt,
    output ctl_t       ctl
);
    kind_e kind;

    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE: begin
                if (shamt == 5'd0 && fn == FN_ADD)     kind = K_ADD;
                else if (shamt == 5'd0 && fn == FN_JR) kind = K_JR;
                else                                   kind = K_NOP;
            end
            OP_ADDI: kind = K_ADDI;
            OP_LW:   kind = K_LW;
            OP_SW:   kind = K_SW;
            OP_BEQ:  kind = K_BEQ;
            OP_J:    kind = K_J;
            OP_JAL:  kind = K_JAL;
            default: kind = K_NOP;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (kind)
            K_ADD:  ctl.reg_we = 1'b1;
            K_ADDI: begin
                ctl.imm_b  = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.dst_rt = 1'b1;
            end
            K_LW: begin
                ctl.imm_b  = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.dst_rt = 1'b1;
                ctl.wd_mem = 1'b1;
            end
            K_SW: begin
                ctl.imm_b  = 1'b1;
                ctl.mem_we = 1'b1;
            end
            K_BEQ: begin
                ctl.branch = 1'b1;
                ctl.sub    = 1'b1;
            end
            K_J:    ctl.jump = 1'b1;
            K_JAL: begin
                ctl.jump   = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.link   = 1'b1;
            end
            K_JR:   ctl.jreg = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y    = sub ? (a - b) : (a + b);
        zero = (y == '0);
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    input  logic [$clog2(N)-1:0] rp,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2,
    output logic [W-1:0]         rdp,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);
    localparam int AW = $clog2(N);

    logic [W-1:0] q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) q[i] <= '0;
        end else if (we && wa != '0) begin
            q[wa] <= wd;
        end
    end

    always_comb begin
        rd1 = (ra1 == AW'(0)) ? '0 : q[ra1];
        rd2 = (ra2 == AW'(0)) ? '0 : q[ra2];
        rdp = (rp  == AW'(0)) ? '0 : q[rp];
    end
endmodule

// File: rtl/cpu_dmem.sv
module cpu_dmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             addr,
    input  logic                     we,
    input  logic [W-1:0]             wd,
    output logic [W-1:0]             rd,
    input  logic [$clog2(DEPTH)-1:0] peek_addr,
    output logic [W-1:0]             peek_data
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic          hit;
    logic [AW-1:0] idx;

    always_comb begin
        hit = (addr[1:0] == 2'b00) && (addr[W-1:AW+2] == '0);
        idx = addr[AW+1:2];
        rd  = hit ? mem[idx] : '0;
        peek_data = mem[peek_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && hit) begin
            mem[idx] <= wd;
        end
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_wr_en,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_wr_addr,
    input  logic [31:0]                   imem_wr_data,
    output logic [31:0]                   pc_out,
    input  logic [4:0]                    reg_peek_addr,
    output logic [31:0]                   reg_peek_data,
    input  logic [$clog2(DMEM_WORDS)-1:0] mem_peek_addr,
    output logic [31:0]                   mem_peek_data
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    word_t imem [IMEM_WORDS];
    word_t pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    word_t instr, sext, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
    logic        fetch_ok, alu_zero;
    logic [4:0]  f_rs, f_rt, f_rd, f_sh, dst;
    logic [5:0]  f_op, f_fn;
    ctl_t        ctl;

    always_ff @(posedge clk) begin
        if (imem_wr_en) imem[imem_wr_addr] <= imem_wr_data;
    end

    always_comb begin
        fetch_ok = (pc_q[1:0] == 2'b00) && (pc_q[31:IAW+2] == '0);
        instr    = fetch_ok ? imem[pc_q[IAW+1:2]] : '0;
        f_op = instr[31:26];
        f_rs = instr[25:21];
        f_rt = instr[20:16];
        f_rd = instr[15:11];
        f_sh = instr[10:6];
        f_fn = instr[5:0];
        sext = {{16{instr[15]}}, instr[15:0]};
    end

    cpu_ctrl u_ctrl (
        .op    (f_op),
        .fn    (f_fn),
        .shamt (f_sh),
        .ctl   (ctl)
    );

    always_comb begin
        if (ctl.link)        dst = LINK_REG;
        else if (ctl.dst_rt) dst = f_rt;
        else                 dst = f_rd;
        alu_b = ctl.imm_b ? sext : rt_val;
    end

    cpu_regfile #(.W(32), .N(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rp    (reg_peek_addr),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rdp   (reg_peek_data),
        .we    (ctl.reg_we),
        .wa    (dst),
        .wd    (wb_data)
    );

    cpu_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sub  (ctl.sub),
        .y    (alu_y),
        .zero (alu_zero)
    );

    cpu_dmem #(.W(32), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (alu_y),
        .we        (ctl.mem_we),
        .wd        (rt_val),
        .rd        (mem_rd),
        .peek_addr (mem_peek_addr),
        .peek_data (mem_peek_data)
    );

    always_comb begin
        if (ctl.link)        wb_data = pc_plus4;
        else if (ctl.wd_mem) wb_data = mem_rd;
        else                 wb_data = alu_y;
    end

    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        br_tgt   = pc_plus4 + {sext[29:0], 2'b00};
        jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
        if (ctl.jreg)                    pc_next = rs_val;
        else if (ctl.jump)               pc_next = jmp_tgt;
        else if (ctl.branch && alu_zero) pc_next = br_tgt;
        else                             pc_next = pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_out = pc_q;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [4:0]  reg_peek_addr,
    input logic [31:0] reg_peek_data
);
    logic        is_jr, is_flow;
    logic [31:0] br_off;

    always_comb begin
        is_jr   = (instr[31:26] == OP_RTYPE) && (instr[5:0] == FN_JR) && (instr[10:6] == 5'd0);
        is_flow = is_jr || (instr[31:26] == OP_BEQ) || (instr[31:26] == OP_J) || (instr[31:26] == OP_JAL);
        br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
    end

    // R1: program counter held at zero during reset
    always @(posedge clk) begin
        if (!rst_n) a_r1_pc_reset: assert (pc == 32'd0);
    end

    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    a_r2_sequential_next: assert property (@(posedge clk) disable iff (!rst_n)
        !is_flow |=> pc == $past(pc) + 32'd4);

    a_r5_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OP_BEQ && rs_val == rt_val) |=> pc == $past(pc + 32'd4 + br_off));

    a_r8_jr_target: assert property (@(posedge clk) disable iff (!rst_n)
        is_jr |=> pc == $past(rs_val));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_peek_addr == 5'd0) |-> (reg_peek_data == 32'd0));
endmodule

bind cpu_core cpu_core_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc            (pc_q),
    .instr         (instr),
    .rs_val        (rs_val),
    .rt_val        (rt_val),
    .reg_peek_addr (reg_peek_addr),
    .reg_peek_data (reg_peek_data)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_wr_en = 1'b0;
    logic [5:0]  imem_wr_addr = '0;
    logic [31:0] imem_wr_data = '0;
    logic [31:0] pc_out;
    logic [4:0]  reg_peek_addr = '0;
    logic [31:0] reg_peek_data;
    logic [5:0]  mem_peek_addr = '0;
    logic [31:0] mem_peek_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] prog [64];

    always #4 clk = ~clk;

    cpu_core i_cpu_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .imem_wr_en    (imem_wr_en),
        .imem_wr_addr  (imem_wr_addr),
        .imem_wr_data  (imem_wr_data),
        .pc_out        (pc_out),
        .reg_peek_addr (reg_peek_addr),
        .reg_peek_data (reg_peek_data),
        .mem_peek_addr (mem_peek_addr),
        .mem_peek_data (mem_peek_data)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int word_tgt);
        return {op, 26'(word_tgt)};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
        reg_peek_addr = 5'(idx);
        #1;
        check(req, $sformatf("r%0d", idx), reg_peek_data, exp);
    endtask

    task automatic chk_mem(input string req, input int idx, input logic [31:0] exp);
        mem_peek_addr = 6'(idx);
        #1;
        check(req, $sformatf("mem[%0d]", idx), mem_peek_data, exp);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem_wr_en   = 1'b1;
            imem_wr_addr = 6'(i);
            imem_wr_data = prog[i];
            @(negedge clk);
        end
        imem_wr_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R2, R3 arithmetic
    task automatic t_arith();
        clear_prog();
        prog[0] = enc_i(6'h08, 0, 1, 5);
        prog[1] = enc_i(6'h08, 0, 2, -3);
        prog[2] = enc_r(1, 2, 3, 6'h20);
        prog[3] = enc_r(3, 3, 4, 6'h20);
        boot();
        run(4);
        chk_reg("R3", 1, 32'd5);
        chk_reg("R3", 2, 32'hFFFF_FFFD);
        chk_reg("R2", 3, 32'd2);
        chk_reg("R2", 4, 32'd4);
        check("R2", "pc", pc_out, 32'd16);
    endtask

    // R4 loads and stores
    task automatic t_mem();
        clear_prog();
        prog[0] = enc_i(6'h08, 0, 1, 32'h40);
        prog[1] = enc_i(6'h08, 0, 2, 1234);
        prog[2] = enc_i(6'h2B, 1, 2, -8);
        prog[3] = enc_i(6'h23, 1, 5, -8);
        prog[4] = enc_i(6'h2B, 1, 5, 4);
        prog[5] = enc_i(6'h08, 0, 6, 77);
        prog[6] = enc_i(6'h2B, 1, 2, 2);
        prog[7] = enc_i(6'h23, 1, 6, 2);
        boot();
        run(8);
        chk_mem("R4", 14, 32'd1234);
        chk_reg("R4", 5, 32'd1234);
        chk_mem("R4", 17, 32'd1234);
        chk_mem("R4", 16, 32'd0);
        chk_reg("R4", 6, 32'd0);
    endtask

    // R1 reset state after a run that left data behind
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "pc", pc_out, 32'd0);
        chk_reg("R1", 5, 32'd0);
        chk_mem("R1", 14, 32'd0);
    endtask

    // R5 branches, forward and backward
    task automatic t_branch();
        clear_prog();
        prog[0]  = enc_i(6'h08, 0, 1, 7);
        prog[1]  = enc_i(6'h08, 0, 2, 7);
        prog[2]  = enc_i(6'h04, 1, 2, 3);
        prog[3]  = enc_i(6'h08, 0, 3, 1);
        prog[4]  = enc_i(6'h08, 0, 3, 2);
        prog[5]  = enc_i(6'h08, 0, 3, 3);
        prog[6]  = enc_i(6'h04, 1, 0, 5);
        prog[7]  = enc_i(6'h08, 0, 4, 9);
        prog[8]  = enc_i(6'h08, 6, 6, 1);
        prog[9]  = enc_i(6'h08, 6, 7, -3);
        prog[10] = enc_i(6'h04, 7, 0, 1);
        prog[11] = enc_i(6'h04, 0, 0, -4);
        prog[12] = enc_i(6'h08, 0, 8, 5);
        boot();
        run(3);
        check("R5", "pc taken", pc_out, 32'd24);
        run(2);
        check("R5", "pc not taken", pc_out, 32'd32);
        chk_reg("R5", 3, 32'd0);
        chk_reg("R5", 4, 32'd9);
        run(12);
        chk_reg("R5", 6, 32'd3);
        chk_reg("R5", 8, 32'd5);
        check("R5", "pc after loop", pc_out, 32'd52);
    endtask

    // R6, R7, R8, R9, R10 jumps, call and return
    task automatic t_jump();
        clear_prog();
        prog[0] = enc_i(6'h08, 0, 1, 32'h20);
        prog[1] = enc_j(6'h03, 4);
        prog[2] = enc_i(6'h08, 0, 2, 11);
        prog[3] = enc_j(6'h02, 6);
        prog[4] = enc_i(6'h08, 0, 3, 22);
        prog[5] = enc_r(31, 0, 0, 6'h08);
        prog[6] = enc_r(1, 1, 0, 6'h20);
        prog[7] = enc_r(1, 0, 0, 6'h08);
        prog[8] = enc_i(6'h08, 0, 4, 33);
        boot();
        run(2);
        check("R7", "pc", pc_out, 32'd16);
        chk_reg("R7", 31, 32'd8);
        run(2);
        check("R8", "pc return", pc_out, 32'd8);
        check("R10", "pc link", pc_out, 32'd8);
        run(2);
        check("R6", "pc", pc_out, 32'd24);
        run(3);
        chk_reg("R9", 0, 32'd0);
        chk_reg("R8", 4, 32'd33);
        chk_reg("R6", 2, 32'd11);
        chk_reg("R7", 3, 32'd22);
        check("R8", "pc final", pc_out, 32'd36);
    endtask

    // R10 same-register read and write, R11 no-ops
    task automatic t_nop();
        clear_prog();
        prog[0] = enc_i(6'h08, 0, 1, 3);
        prog[1] = enc_r(1, 1, 1, 6'h20);
        prog[2] = enc_i(6'h08, 1, 2, 0);
        prog[3] = {6'h3F, 5'd1, 5'd5, 16'h0000};
        prog[4] = enc_r(1, 1, 5, 6'h21);
        boot();
        run(5);
        chk_reg("R10", 1, 32'd6);
        chk_reg("R10", 2, 32'd6);
        chk_reg("R11", 5, 32'd0);
        chk_mem("R11", 0, 32'd0);
        check("R11", "pc", pc_out, 32'd20);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_arith();
        t_mem();
        t_reset();
        t_branch();
        t_jump();
        t_nop();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule